// File: doc/BRIEF.md
# Strap-Addressed I2C Slave Byte Engine

This block is the serial front end of a small register-controlled device on an I2C bus. It brings SCL and SDA into the system clock domain through synchronisers and finds START, repeated START and STOP conditions on the synchronised lines. It then shifts bytes in and out and answers its own 7-bit address with an acknowledge. Any other address makes it stay silent until the next START.

The bus address is not programmable. It is looked up from two strap pins, which are sampled once when reset ends, and the four possible addresses are not contiguous. Toward the register logic the engine gives a byte-level view. It pulses a session strobe with the direction bit when its address matches. It delivers each received byte with its position in the transfer, asks for a transmit byte before each byte it sends, reports the master's ACK or NACK, and pulses a strobe at STOP. A repeated START opens a new address phase but does not end the session. Because of this, a register pointer written in one phase still governs the read phase that follows.

Top module: `i2c_strap_slave`

## Requirements
- R1: One clock after the synchronised reset is released, the address is captured from the straps {strap_hi, strap_lo}: 00 gives 7'h18, 10 gives 7'h1A, 01 gives 7'h4C and 11 gives 7'h4E.
- R2: Strap changes after the capture have no effect on the address the engine answers.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Any START, including a repeated one, releases SDA and begins a new address phase.
- R4: The first byte after START holds the address in bits 7..1 and the direction in bit 0, where 1 means the master reads. On a match the engine pulls SDA low for the ninth clock and pulses sess_start for one cycle, with sess_rnw equal to the direction bit.
- R5: On an address mismatch SDA stays released, and nothing is acknowledged or delivered until the next START.
- R6: In a write session every received byte, MSB first, is acknowledged on its ninth clock. Each byte is presented with a one-cycle rx_valid and an rx_index that starts at 0 after each address match and counts up, saturating at its largest value.
- R7: In a read session the engine pulses tx_req when its address is acknowledged. It shifts out tx_data MSB first and changes SDA only after falling SCL edges. SDA is open-drain: sda_oe is 1 exactly when a 0 is sent.
- R8: On the ninth clock of a read byte the engine pulses mack_valid with mack_nack equal to SDA. On an ACK (0) it also pulses tx_req and sends another byte. On a NACK (1) it keeps SDA released until the next START.
- R9: stop_seen pulses once at a STOP that ends an addressed session. A repeated START gives no stop_seen and keeps the session.
- R10: While reset is asserted, sda_oe and all strobes (sess_start, rx_valid, tx_req, mack_valid, stop_seen) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_hi | input | 1 | Upper address strap |
| strap_lo | input | 1 | Lower address strap |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sess_start | output | 1 | One-cycle pulse on an address match |
| sess_rnw | output | 1 | Direction bit of the matched address byte |
| rx_valid | output | 1 | One-cycle pulse with a received byte |
| rx_data | output | 8 | Received byte |
| rx_index | output | IDX_W | Position of the byte in the write phase |
| tx_req | output | 1 | One-cycle request for the next transmit byte |
| tx_data | input | 8 | Transmit byte, sampled when the acknowledge clock ends |
| mack_valid | output | 1 | One-cycle pulse with the master acknowledge |
| mack_nack | output | 1 | Master acknowledge value, 1 for NACK |
| stop_seen | output | 1 | One-cycle pulse at the STOP that ends a session |

## Verification
The bench builds the engine with a three-stage synchroniser and a two-bit byte index. The deeper synchroniser adds latency, which shows whether SDA still changes only while SCL is low. The narrow index lets a five-byte write reach index saturation. The bench resets the engine once for each strap setting and changes the straps after each capture. It runs write, mismatch and repeated-START read sessions. On every clock it checks that SDA is released whenever the master owns the line.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_t;

  // straps given as {hi, lo}
  function automatic logic [ADDR_W-1:0] strap_lookup(input logic [1:0] st);
    logic [ADDR_W-1:0] a;
    case (st)
      2'b00:   a = 7'h18;
      2'b10:   a = 7'h1A;
      2'b01:   a = 7'h4C;
      default: a = 7'h4E;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic [STAGES-1:0] scl_pipe_n, sda_pipe_n;
  logic scl_q, sda_q;

  always_comb begin
    scl_pipe_n = {scl_pipe[STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_hi,
  input  logic              strap_lo,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_valid
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              valid_q, valid_n;
  logic              cap_en;

  assign cap_en = ~valid_q;

  always_comb begin
    addr_n  = addr_q;
    valid_n = valid_q;
    if (cap_en) begin
      addr_n  = strap_lookup({strap_hi, strap_lo});
      valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= addr_n;
      valid_q <= valid_n;
    end
  end

  assign dev_addr   = addr_q;
  assign addr_valid = valid_q;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_slv_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              sess_start,
  output logic              sess_rnw,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_index,
  output logic              tx_req,
  output logic              mack_valid,
  output logic              mack_nack,
  output logic              stop_seen
);
  localparam logic [BIT_CNT_W-1:0] CNT_LAST = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] CNT_FULL = BIT_CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0]     IDX_MAX  = '1;

  slv_state_t         state_q, state_n;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sr_q, sr_n;
  logic               oe_q, oe_n;
  logic               rnw_q, rnw_n;
  logic               hit_q, hit_n;
  logic               act_q, act_n;
  logic               more_q, more_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [BYTE_W-1:0]  rxd_q, rxd_n;
  logic               nack_q, nack_n;
  logic               p_sess_q, p_sess_n;
  logic               p_rx_q, p_rx_n;
  logic               p_txr_q, p_txr_n;
  logic               p_mack_q, p_mack_n;
  logic               p_stop_q, p_stop_n;
  logic [BYTE_W-1:0]  shift_in;

  assign shift_in = {sr_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    sr_n     = sr_q;
    oe_n     = oe_q;
    rnw_n    = rnw_q;
    hit_n    = hit_q;
    act_n    = act_q;
    more_n   = more_q;
    idx_n    = idx_q;
    rxd_n    = rxd_q;
    nack_n   = nack_q;
    p_sess_n = 1'b0;
    p_rx_n   = 1'b0;
    p_txr_n  = 1'b0;
    p_mack_n = 1'b0;
    p_stop_n = 1'b0;

    if (stop_det) begin
      state_n  = ST_IDLE;
      oe_n     = 1'b0;
      p_stop_n = act_q;
      act_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sr_n  = shift_in;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              hit_n = addr_valid && (sr_q[ADDR_W-1:0] == dev_addr);
              rnw_n = sda_s;
              if (addr_valid && (sr_q[ADDR_W-1:0] == dev_addr)) begin
                p_sess_n = 1'b1;
                act_n    = 1'b1;
                idx_n    = '0;
              end
            end
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (hit_q) begin
              state_n = ST_ADDR_ACK;
              oe_n    = 1'b1;
              p_txr_n = rnw_q;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rnw_q) begin
              state_n = ST_RD;
              sr_n    = tx_data;
              oe_n    = ~tx_data[BYTE_W-1];
              cnt_n   = BIT_CNT_W'(1);
            end else begin
              state_n = ST_WR;
              oe_n    = 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sr_n  = shift_in;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              p_rx_n = 1'b1;
              rxd_n  = shift_in;
            end
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            state_n = ST_WR_ACK;
            oe_n    = 1'b1;
            if (idx_q != IDX_MAX) idx_n = idx_q + 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_n = ST_WR;
            cnt_n   = '0;
            oe_n    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q != CNT_FULL) begin
              oe_n  = ~sr_q[BYTE_W-2];
              sr_n  = {sr_q[BYTE_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_RD_ACK;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            p_mack_n = 1'b1;
            nack_n   = sda_s;
            more_n   = ~sda_s;
            p_txr_n  = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              state_n = ST_RD;
              sr_n    = tx_data;
              oe_n    = ~tx_data[BYTE_W-1];
              cnt_n   = BIT_CNT_W'(1);
            end else begin
              state_n = ST_IDLE;
              oe_n    = 1'b0;
            end
          end
        end
        default: begin
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sr_q     <= '0;
      oe_q     <= 1'b0;
      rnw_q    <= 1'b0;
      hit_q    <= 1'b0;
      act_q    <= 1'b0;
      more_q   <= 1'b0;
      idx_q    <= '0;
      rxd_q    <= '0;
      nack_q   <= 1'b0;
      p_sess_q <= 1'b0;
      p_rx_q   <= 1'b0;
      p_txr_q  <= 1'b0;
      p_mack_q <= 1'b0;
      p_stop_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      sr_q     <= sr_n;
      oe_q     <= oe_n;
      rnw_q    <= rnw_n;
      hit_q    <= hit_n;
      act_q    <= act_n;
      more_q   <= more_n;
      idx_q    <= idx_n;
      rxd_q    <= rxd_n;
      nack_q   <= nack_n;
      p_sess_q <= p_sess_n;
      p_rx_q   <= p_rx_n;
      p_txr_q  <= p_txr_n;
      p_mack_q <= p_mack_n;
      p_stop_q <= p_stop_n;
    end
  end

  assign sda_oe     = oe_q;
  assign sess_start = p_sess_q;
  assign sess_rnw   = rnw_q;
  assign rx_valid   = p_rx_q;
  assign rx_data    = rxd_q;
  assign rx_index   = idx_q;
  assign tx_req     = p_txr_q;
  assign mack_valid = p_mack_q;
  assign mack_nack  = nack_q;
  assign stop_seen  = p_stop_q;
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              sess_start,
  output logic              sess_rnw,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_index,
  output logic              tx_req,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              mack_valid,
  output logic              mack_nack,
  output logic              stop_seen
);
  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic              addr_valid;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_strap_addr u_addr (
    .clk        (clk),
    .rst_n      (rst_ns),
    .strap_hi   (strap_hi),
    .strap_lo   (strap_lo),
    .dev_addr   (dev_addr),
    .addr_valid (addr_valid)
  );

  i2c_byte_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_ns),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .dev_addr   (dev_addr),
    .addr_valid (addr_valid),
    .tx_data    (tx_data),
    .sda_oe     (sda_oe),
    .sess_start (sess_start),
    .sess_rnw   (sess_rnw),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_index   (rx_index),
    .tx_req     (tx_req),
    .mack_valid (mack_valid),
    .mack_nack  (mack_nack),
    .stop_seen  (stop_seen)
  );
endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       sess_start,
  input logic       rx_valid,
  input logic       stop_seen,
  input logic       tx_req,
  input logic       mack_valid,
  input logic       mack_nack,
  input logic [6:0] dev_addr,
  input logic       addr_valid
);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

  assert_start_release_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    start_det |=> !sda_oe);

  // SDA moves only while SCL is low, except the release at a bus condition
  assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(sda_oe) |-> (!scl_s || $past(start_det) || $past(stop_det)));

  assert_ack_requests_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (mack_valid && !mack_nack) |-> tx_req);

  assert_nack_no_req_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (mack_valid && mack_nack) |-> !tx_req);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({sess_start, rx_valid, stop_seen, mack_valid}));
endmodule

bind i2c_strap_slave i2c_strap_slave_chk u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_oe     (sda_oe),
  .sess_start (sess_start),
  .rx_valid   (rx_valid),
  .stop_seen  (stop_seen),
  .tx_req     (tx_req),
  .mack_valid (mack_valid),
  .mack_nack  (mack_nack),
  .dev_addr   (dev_addr),
  .addr_valid (addr_valid)
);

// File: tb/i2c_strap_slave_tb.sv
module i2c_strap_slave_tb;
  localparam int IDX_W = 2;
  localparam int Q     = 8;

  logic clk, rst_n, strap_hi, strap_lo;
  logic scl_m, sda_m;
  logic sda_oe, sess_start, sess_rnw, rx_valid, tx_req, mack_valid, mack_nack, stop_seen;
  logic [7:0] rx_data, tx_data;
  logic [IDX_W-1:0] rx_index;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_strap_slave #(.SYNC_STAGES(3), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .sess_start(sess_start), .sess_rnw(sess_rnw), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_index(rx_index), .tx_req(tx_req), .tx_data(tx_data),
    .mack_valid(mack_valid), .mack_nack(mack_nack), .stop_seen(stop_seen)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic quiet = 1'b0;

  // behavioural model of the register side
  int n_sess = 0, n_stop = 0, n_txreq = 0, n_mack = 0;
  logic last_rnw = 1'b0, last_nack = 1'b0;
  int rx_dq[$];
  int rx_iq[$];
  logic [7:0] tx_q[$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sess_start) begin n_sess++; last_rnw = sess_rnw; end
      if (rx_valid) begin rx_dq.push_back(int'(rx_data)); rx_iq.push_back(int'(rx_index)); end
      if (stop_seen) n_stop++;
      if (mack_valid) begin n_mack++; last_nack = mack_nack; end
      if (tx_req) begin
        n_txreq++;
        if (tx_q.size() > 0) tx_data <= tx_q.pop_front();
        else tx_data <= 8'h00;
      end
      // R7/R5: whenever the master owns SDA the engine must be released
      if (quiet) check("R5/R7 released while master drives", int'(sda_oe), 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic hi, input logic lo);
    rst_n = 1'b0; strap_hi = hi; strap_lo = lo;
    scl_m = 1'b1; sda_m = 1'b1;
    tick(4);
    check("R10 reset outputs",
          int'({sda_oe, sess_start, rx_valid, tx_req, mack_valid, stop_seen}), 0);
    rst_n = 1'b1;
    tick(10);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clock_bit(input logic b, input logic q, output logic s);
    sda_m = b; tick(Q);
    quiet = q;
    scl_m = 1'b1; tick(Q);
    s = sda_line;
    tick(Q);
    quiet = 1'b0;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b1, s);
    clock_bit(1'b1, !exp_ack, s);
    check(req, int'(s), exp_ack ? 0 : 1);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic nack, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, 1'b0, s);
      got[i] = s;
    end
    check(req, int'(got), int'(exp));
    clock_bit(nack, 1'b1, s);
  endtask

  function automatic logic [6:0] exp_addr(input logic hi, input logic lo);
    case ({hi, lo})
      2'b00: return 7'h18;
      2'b10: return 7'h1A;
      2'b01: return 7'h4C;
      default: return 7'h4E;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s0, st0, tr0;
    tx_data = 8'h00;
    rst_n = 1'b0; strap_hi = 1'b0; strap_lo = 1'b0; scl_m = 1'b1; sda_m = 1'b1;

    // R1, R2, R5: each strap setting, straps flipped after capture
    for (int k = 0; k < 4; k++) begin
      logic hi, lo;
      logic [6:0] a, other;
      hi = k[1]; lo = k[0];
      a = exp_addr(hi, lo);
      other = exp_addr(~hi, ~lo);
      do_reset(hi, lo);
      strap_hi = ~hi; strap_lo = ~lo;
      s0 = n_sess;
      bus_start();
      send_byte({a, 1'b0}, 1'b1, "R1 strap address acknowledged");
      bus_stop();
      check("R4 session strobe on match", n_sess - s0, 1);
      bus_start();
      send_byte({other, 1'b0}, 1'b0, "R2 new strap address ignored");
      bus_stop();
      check("R2 no session for new strap value", n_sess - s0, 1);
    end

    // R6, R9: write session with index saturation
    do_reset(1'b0, 1'b0);
    rx_dq.delete(); rx_iq.delete();
    s0 = n_sess; st0 = n_stop;
    bus_start();
    send_byte(8'h30, 1'b1, "R4 write address ack");
    check("R4 rnw is write", int'(last_rnw), 0);
    send_byte(8'hA5, 1'b1, "R6 byte0 ack");
    send_byte(8'h3C, 1'b1, "R6 byte1 ack");
    send_byte(8'h01, 1'b1, "R6 byte2 ack");
    send_byte(8'hFE, 1'b1, "R6 byte3 ack");
    send_byte(8'h80, 1'b1, "R6 byte4 ack");
    check("R9 no stop strobe mid session", n_stop - st0, 0);
    bus_stop();
    check("R9 stop strobe", n_stop - st0, 1);
    check("R6 byte count", rx_dq.size(), 5);
    if (rx_dq.size() == 5) begin
      check("R6 data0", rx_dq[0], 'hA5); check("R6 idx0", rx_iq[0], 0);
      check("R6 data1", rx_dq[1], 'h3C); check("R6 idx1", rx_iq[1], 1);
      check("R6 data2", rx_dq[2], 'h01); check("R6 idx2", rx_iq[2], 2);
      check("R6 data3", rx_dq[3], 'hFE); check("R6 idx3", rx_iq[3], 3);
      check("R6 data4", rx_dq[4], 'h80); check("R6 idx4 saturated", rx_iq[4], 3);
    end

    // R5: mismatch ignores the rest of the transfer
    rx_dq.delete(); rx_iq.delete();
    s0 = n_sess; st0 = n_stop;
    bus_start();
    send_byte({7'h1A, 1'b0}, 1'b0, "R5 foreign address not acked");
    send_byte(8'h55, 1'b0, "R5 following byte not acked");
    bus_stop();
    check("R5 no session", n_sess - s0, 0);
    check("R5 no data delivered", rx_dq.size(), 0);
    check("R9 no stop strobe without session", n_stop - st0, 0);

    // R3, R7, R8, R9: write pointer, repeated START, read
    rx_dq.delete(); rx_iq.delete();
    s0 = n_sess; st0 = n_stop; tr0 = n_txreq;
    tx_q.push_back(8'h96); tx_q.push_back(8'h5A);
    bus_start();
    send_byte(8'h30, 1'b1, "R4 address ack before pointer");
    send_byte(8'h00, 1'b1, "R6 pointer byte ack");
    bus_start();
    check("R9 repeated START gives no stop strobe", n_stop - st0, 0);
    send_byte(8'h31, 1'b1, "R3 address ack after repeated START");
    check("R3 new address phase after repeated START", n_sess - s0, 2);
    check("R4 rnw is read", int'(last_rnw), 1);
    check("R7 transmit request at address", n_txreq - tr0, 1);
    recv_byte(8'h96, 1'b0, "R7 first read byte");
    check("R8 master ack reported", int'(last_nack), 0);
    check("R8 ack requests next byte", n_txreq - tr0, 2);
    recv_byte(8'h5A, 1'b1, "R7 second read byte");
    check("R8 master nack reported", int'(last_nack), 1);
    check("R8 nack requests nothing", n_txreq - tr0, 2);
    check("R8 two acknowledge reports", n_mack >= 2 ? 1 : 0, 1);
    send_byte(8'hFF, 1'b0, "R8 released after nack");
    bus_stop();
    check("R9 stop after read session", n_stop - st0, 1);

    // R3: START aborts a byte midway and readdresses
    s0 = n_sess;
    bus_start();
    begin
      logic s;
      clock_bit(1'b0, 1'b1, s);
      clock_bit(1'b0, 1'b1, s);
      clock_bit(1'b1, 1'b1, s);
    end
    bus_start();
    send_byte(8'h30, 1'b1, "R3 START restarts address phase");
    bus_stop();
    check("R3 one session from restarted phase", n_sess - s0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule